// File: doc/BRIEF.md
# Two-Level Sample Accumulator

This block integrates a stream of signed samples over a window whose length is the product of two programmable counts. An inner stage adds up a fixed number of valid samples. Each inner total is passed to an outer stage, which adds up a fixed number of inner totals. When the outer stage reaches its count, the grand total is copied into a result register and an interrupt is raised. Both stages then start again at once.

The two counts are plain inputs. The block samples them during reset and again at each completed window. Changing them while a window is running therefore affects only the window that follows. A count of zero is handled as one. The accumulators are wide enough that the largest window of extreme samples cannot wrap.

Top module: `dual_stage_accum`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `total` reads 0 and `irq` reads 0.
- R2: The inner stage counts only cycles in which `smp_valid` is high. The data on cycles with `smp_valid` low does not enter the total. The inner stage hands on its sum after exactly P valid samples, where P is the inner count.
- R3: `total` equals the two's-complement sum of the P×C valid samples in a window, where C is the outer count. It is updated on the clock edge that captures the window's last sample.
- R4: `irq` goes high on that same edge and stays high, with `total` unchanged, until an acknowledge removes it.
- R5: If `irq_ack` is high at an edge where no window completes, `irq` goes low. If a window completes at the same edge as the acknowledge, `irq` stays high and `total` takes the new value.
- R6: A value of 0 on `pre_cnt` or `cyc_cnt` behaves exactly like a value of 1.
- R7: `pre_cnt` and `cyc_cnt` are sampled during reset and at each window completion. A change made between these points does not alter the running window and applies to the next one.
- R8: With `smp_valid` held high continuously, every sample lands in exactly one window. No sample is lost or counted twice at inner or outer boundaries.
- R9: `total` is DATA_W+2·CNT_W bits wide. A window of 255×255 samples of −32768 (the defaults) gives exactly −2130739200.
- R10: Between completions, `total` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample qualifier |
| smp_data | input | DATA_W | Signed sample |
| pre_cnt | input | CNT_W | Inner count (samples per inner sum) |
| cyc_cnt | input | CNT_W | Outer count (inner sums per window) |
| irq_ack | input | 1 | Clears the interrupt |
| total | output | DATA_W+2·CNT_W | Latched signed window total |
| irq | output | 1 | Window-complete interrupt |

## Verification
Some properties are checked on every cycle:
- the interrupt holds until acknowledged and only rises on a completion;
- an acknowledge without a completion clears it;
- the total and the active counts stay stable between completions;
- both stage counters remain below their nonzero limits.

The bench scenarios are needed for the rest. These cover the arithmetic value of each total, gaps in the valid signal, boundary continuity under back-to-back samples, deferred count changes, zero counts, the acknowledge that coincides with a completion, and the full-width extreme window.

// File: rtl/acc2_pkg.sv
// Package: defaults and width helper shared by the two-level accumulator.
// Assumes: widths are small positive integers.
package acc2_pkg;
    localparam int DEF_DATA_W = 16;
    localparam int DEF_CNT_W  = 8;

    // Width needed to add up 2**(levels*cnt_w) samples of dw bits without wrapping.
    function automatic int acc_width(input int dw, input int cw, input int levels);
        return dw + levels * cw;
    endfunction
endpackage

// File: rtl/cnt_cfg_hold.sv
// Module: holds the active count limits. Each raw count is captured during
// reset or when load is high, and a zero count is replaced by one.
// Assumes: load pulses for one cycle at each window boundary.
module cnt_cfg_hold #(
    parameter int N_FIELDS = 2,
    parameter int CNT_W    = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             load,
    input  logic [N_FIELDS-1:0][CNT_W-1:0]   raw,
    output logic [N_FIELDS-1:0][CNT_W-1:0]   lim
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    for (genvar g = 0; g < N_FIELDS; g++) begin : g_field
        logic [CNT_W-1:0] q;

        // Capture the normalised count at reset or at a boundary.
        always_ff @(posedge clk) begin
            if (!rst_n || load) begin
                q <= (raw[g] == '0) ? ONE : raw[g];
            end
        end

        assign lim[g] = q;
    end
endmodule

// File: rtl/accum_stage.sv
// Module: one accumulate-and-count stage. Each step adds the sign-extended
// addend. On the limit-th step, done is high, result carries the finished
// sum, and the stage clears itself in the same edge.
// Assumes: limit >= 1, OUT_W >= IN_W, and limit changes only when done.
module accum_stage #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 24,
    parameter int CNT_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step,
    input  logic signed [IN_W-1:0]  addend,
    input  logic [CNT_W-1:0]        limit,
    output logic                    done,
    output logic signed [OUT_W-1:0] result,
    output logic [CNT_W-1:0]        count
);
    localparam int EXT_W = OUT_W - IN_W;

    logic signed [OUT_W-1:0] acc_q;
    logic signed [OUT_W-1:0] addend_ext;

    // Sign-extend the addend to the accumulator width.
    always_comb begin
        if (EXT_W > 0) begin
            addend_ext = OUT_W'(addend);
        end else begin
            addend_ext = addend[OUT_W-1:0];
        end
    end

    // Running sum including the current addend, and the last-step flag.
    always_comb begin
        result = acc_q + addend_ext;
        done   = step && (count == limit - CNT_W'(1));
    end

    // Advance on each step and restart after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            count <= '0;
        end else if (step) begin
            if (done) begin
                acc_q <= '0;
                count <= '0;
            end else begin
                acc_q <= result;
                count <= count + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/dual_stage_accum.sv
// Module: two-level sample accumulator. The inner stage sums pre_cnt valid
// samples. The outer stage sums cyc_cnt inner results. At the end of a
// window, the total is latched and irq is set until irq_ack.
// Assumes: synchronous active-low reset; irq_ack is level-sensitive.
module dual_stage_accum
    import acc2_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int CNT_W  = DEF_CNT_W
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             smp_valid,
    input  logic signed [DATA_W-1:0]         smp_data,
    input  logic [CNT_W-1:0]                 pre_cnt,
    input  logic [CNT_W-1:0]                 cyc_cnt,
    input  logic                             irq_ack,
    output logic signed [DATA_W+2*CNT_W-1:0] total,
    output logic                             irq
);
    localparam int ACC1_W = acc_width(DATA_W, CNT_W, 1);
    localparam int ACC2_W = acc_width(DATA_W, CNT_W, 2);

    logic [1:0][CNT_W-1:0]   lims;
    logic [CNT_W-1:0]        pre_lim, cyc_lim, cnt1, cnt2;
    logic                    done1, done_all;
    logic signed [ACC1_W-1:0] sum1_next;
    logic signed [ACC2_W-1:0] sum2_next;

    cnt_cfg_hold #(.N_FIELDS(2), .CNT_W(CNT_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (done_all),
        .raw   ({cyc_cnt, pre_cnt}),
        .lim   (lims)
    );

    assign pre_lim = lims[0];
    assign cyc_lim = lims[1];

    accum_stage #(.IN_W(DATA_W), .OUT_W(ACC1_W), .CNT_W(CNT_W)) u_inner (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (smp_valid),
        .addend (smp_data),
        .limit  (pre_lim),
        .done   (done1),
        .result (sum1_next),
        .count  (cnt1)
    );

    accum_stage #(.IN_W(ACC1_W), .OUT_W(ACC2_W), .CNT_W(CNT_W)) u_outer (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (done1),
        .addend (sum1_next),
        .limit  (cyc_lim),
        .done   (done_all),
        .result (sum2_next),
        .count  (cnt2)
    );

    // Latch the window total and keep the interrupt (completion beats acknowledge).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            total <= '0;
            irq   <= 1'b0;
        end else begin
            if (done_all) begin
                total <= sum2_next;
            end
            if (done_all) begin
                irq <= 1'b1;
            end else if (irq_ack) begin
                irq <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/accum_chk.sv
// Module: cycle-level checks for dual_stage_accum, bound to every instance.
// Assumes: it sees the top's internal completion flag, counters and limits.
module accum_chk #(
    parameter int CNT_W = 8,
    parameter int ACC_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq,
    input logic             irq_ack,
    input logic [ACC_W-1:0] total,
    input logic             done_all,
    input logic [CNT_W-1:0] cnt1,
    input logic [CNT_W-1:0] cnt2,
    input logic [CNT_W-1:0] pre_lim,
    input logic [CNT_W-1:0] cyc_lim
);
    a_r4_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !irq_ack |=> irq);

    a_r4_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(done_all));

    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack && !done_all |=> !irq);

    a_r10_total_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !done_all |=> $stable(total));

    a_r7_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !done_all |=> ($stable(pre_lim) && $stable(cyc_lim)));

    a_r6_limits_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_lim != '0) && (cyc_lim != '0));

    a_r2_inner_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt1 < pre_lim);

    a_r3_outer_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt2 < cyc_lim);
endmodule

bind dual_stage_accum accum_chk #(.CNT_W(CNT_W), .ACC_W(ACC2_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq      (irq),
    .irq_ack  (irq_ack),
    .total    (total),
    .done_all (done_all),
    .cnt1     (cnt1),
    .cnt2     (cnt2),
    .pre_lim  (pre_lim),
    .cyc_lim  (cyc_lim)
);

// File: tb/dual_stage_accum_tb_top.sv
module dual_stage_accum_tb_top;
    localparam int DW = 16;
    localparam int CW = 8;
    localparam int AW = DW + 2 * CW;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                 rst_n;
    logic                 smp_valid;
    logic signed [DW-1:0] smp_data;
    logic [CW-1:0]        pre_cnt, cyc_cnt;
    logic                 mon_ack = 1'b0;
    logic                 tb_ack;
    wire                  irq_ack = mon_ack | tb_ack;
    logic signed [AW-1:0] total;
    logic                 irq;

    dual_stage_accum #(.DATA_W(DW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .pre_cnt(pre_cnt), .cyc_cnt(cyc_cnt), .irq_ack(irq_ack),
        .total(total), .irq(irq)
    );

    int     n_chk = 0, n_err = 0, m_chk = 0, m_err = 0, wd_cnt = 0;
    longint exp_q[$];
    longint mdl_sum = 0, mdl_last = 0;
    int     mdl_n = 0, mdl_pre = 1, mdl_cyc = 1;
    bit     push_en = 1'b1, auto_ack = 1'b1, prev_irq = 1'b0;

    function automatic int norm(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: apply one input cycle and update the window model / scoreboard.
    task automatic send(input int d, input bit v, input bit a = 1'b0);
        @(negedge clk);
        smp_valid = v;
        smp_data  = DW'(d);
        tb_ack    = a;
        if (v) begin
            mdl_sum += longint'(d);
            mdl_n++;
            if (mdl_n == mdl_pre * mdl_cyc) begin
                mdl_last = mdl_sum;
                if (push_en) exp_q.push_back(mdl_sum);
                mdl_sum = 0;
                mdl_n   = 0;
                mdl_pre = norm(int'(pre_cnt));
                mdl_cyc = norm(int'(cyc_cnt));
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) send(12345, 1'b0);   // R2: data ignored while invalid
    endtask

    // Monitor: on each rising interrupt compare the total with the scoreboard.
    always @(negedge clk) begin
        mon_ack = 1'b0;
        if (rst_n && irq && !prev_irq) begin
            m_chk++;
            if (exp_q.size() == 0) begin
                m_err++;
                $display("FAIL R3 actual=%0d expected=none queued", total);
            end else begin
                longint e;
                e = exp_q.pop_front();
                if (longint'(total) != e) begin
                    m_err++;
                    $display("FAIL R3 actual=%0d expected=%0d", total, e);
                end
            end
            if (auto_ack) mon_ack = 1'b1;
        end
        prev_irq = irq;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        wd_cnt++;
        if (wd_cnt > 150000) begin
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", wd_cnt);
            $display("Result: errors=%0d of %0d checks", n_err + m_err + 1, n_chk + m_chk + 1);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; smp_valid = 1'b0; smp_data = '0; tb_ack = 1'b0;
        pre_cnt = 8'd3; cyc_cnt = 8'd2;
        mdl_pre = 3; mdl_cyc = 2;
        repeat (3) @(negedge clk);
        chk(total == 0, "R1", total, 0);
        chk(irq == 1'b0, "R1", irq, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk(total == 0 && irq == 1'b0, "R1", total, 0);

        // R2/R3: 3x2 window with invalid gaps carrying junk data.
        for (int i = 0; i < 6; i++) begin
            send(i * 100 - 250, 1'b1);
            send(999, 1'b0);
        end
        idle(3);

        // R8: continuous samples spanning two windows.
        for (int i = 0; i < 12; i++) send(5 - i * 37, 1'b1);
        idle(3);

        // R7: change counts mid-window; the old 3x2 length still applies.
        send(11, 1'b1);
        pre_cnt = 8'd2; cyc_cnt = 8'd2;
        for (int i = 0; i < 3; i++) send(-20 + i, 1'b1);
        @(posedge clk); #1;
        chk(irq == 1'b0, "R7", irq, 0);
        send(40, 1'b1);
        send(41, 1'b1);
        @(posedge clk); #1;
        chk(irq == 1'b1, "R7", irq, 1);
        pre_cnt = 8'd0; cyc_cnt = 8'd2;
        for (int i = 0; i < 4; i++) send(300 + i, 1'b1);   // 2x2 window

        // R6: zero inner count acts as one (1x2 window).
        pre_cnt = 8'd2; cyc_cnt = 8'd0;
        send(-7, 1'b1);
        send(9, 1'b1);
        @(posedge clk); #1;
        chk(irq == 1'b1, "R6", irq, 1);
        // R6: zero outer count acts as one (2x1 window).
        pre_cnt = 8'd1; cyc_cnt = 8'd1;
        send(1000, 1'b1);
        send(-3000, 1'b1);
        @(posedge clk); #1;
        chk(irq == 1'b1, "R6", irq, 1);
        idle(3);

        // R4/R10: interrupt holds without acknowledge; total stays put.
        auto_ack = 1'b0;
        send(77, 1'b1);
        idle(5);
        chk(irq == 1'b1, "R4", irq, 1);
        chk(total == 77, "R10", total, 77);

        // R5: acknowledge coinciding with a completion keeps irq set.
        push_en = 1'b0;
        send(-5, 1'b1, 1'b1);
        @(posedge clk); #1;
        chk(irq == 1'b1, "R5", irq, 1);
        chk(longint'(total) == mdl_last, "R5", total, mdl_last);
        send(0, 1'b0, 1'b1);
        @(posedge clk); #1;
        chk(irq == 1'b0, "R5", irq, 0);
        send(0, 1'b0, 1'b0);
        push_en  = 1'b1;
        auto_ack = 1'b1;

        // R9: largest window of the most negative sample.
        pre_cnt = 8'd255; cyc_cnt = 8'd255;
        send(3, 1'b1);
        idle(3);
        for (int i = 0; i < 255 * 255; i++) send(-32768, 1'b1);
        idle(3);
        chk(longint'(total) == -64'sd2130739200, "R9", total, -64'sd2130739200);

        chk(exp_q.size() == 0, "R3", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", n_err + m_err, n_chk + m_chk);
        $finish;
    end
endmodule